// File: doc/BRIEF.md
# Deferred Interrupt-Enable and Step-Block Controller

This sequential block sits beside an instruction-emulation sequencer and makes an interrupt enable take effect only after one further macro instruction has completed. When the sequencer reports that it has emulated the enable-interrupt instruction, the block raises a pending flag. The next instruction's fetch-transform tells the block what class of instruction follows. A short instruction releases the enable at the next instruction read. A storage-reference or enhanced instruction, which may span several memory references, releases it only at its end-of-instruction increment. The release is a single-cycle set pulse, and the pending flag drops in that same cycle.

The block also drives a block-mask that keeps the macro-halt interrupt off while a multi-reference or enhanced instruction is being emulated. It produces a single-cycle clear-halt pulse whenever the fetch-transform runs in step mode, which re-arms the halt interrupt. Master clear returns everything to rest. Interrupt arbitration is handled elsewhere.

The enable path is a four-state machine. IDLE moves to ARMED on an enable-interrupt event. ARMED moves to WAIT_RD on a fetch-transform of class simple or skip-type-2, and to WAIT_EOI on a fetch-transform of class storage or enhanced. WAIT_RD returns to IDLE on a read and fires the set pulse. WAIT_EOI returns to IDLE on an end-of-instruction and fires the set pulse. From any state, an enable-interrupt event restarts the machine in ARMED and master clear forces IDLE. The mask path is a two-state machine. OPEN moves to HELD on a fetch-transform of any class except simple. HELD returns to OPEN on end-of-instruction or master clear.

Top module: `ie_defer_ctl`

## Requirements
- R1: Reset or a master-clear strobe (`mclr_i`) drives all four outputs low on the next cycle. Master clear takes priority over every other strobe in the same cycle.
- R2: An enable-interrupt strobe (`ei_done_i`) raises `pend_o` on the next cycle. `pend_o` stays high until the release pulse.
- R3: Instruction class `cls_i` is encoded as 2'b00 simple, 2'b01 storage reference, 2'b10 enhanced and 2'b11 enhanced skip type 2. After a fetch-transform (`fetch_xf_i`) of class 2'b00 or 2'b11 while pending, the release happens on the first later read strobe (`rdnext_i`). End-of-instruction strobes in between do not release it.
- R4: After a fetch-transform of class 2'b01 or 2'b10 while pending, the release happens on the first later end-of-instruction strobe (`eoi_i`). Read strobes in between do not release it.
- R5: The release is `ie_set_o` high for exactly one cycle, in the cycle after the releasing strobe. `pend_o` is low in that same cycle.
- R6: Read and end-of-instruction strobes that arrive while pending, but before the fetch-transform, do not release the enable.
- R7: If an enable-interrupt strobe and an end-of-instruction strobe arrive together, `pend_o` stays high and no pulse is issued. The class is then taken from the following fetch-transform.
- R8: A fetch-transform with `cls_i` not equal to 2'b00 raises `blk_o` on the next cycle. `blk_o` stays high until the cycle after an end-of-instruction or master-clear strobe.
- R9: A fetch-transform with `step_i` high gives `clr_halt_o` high for exactly the next cycle. With `step_i` low it gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ei_done_i | input | 1 | Enable-interrupt instruction emulated (strobe) |
| rdnext_i | input | 1 | Next-instruction read (strobe) |
| fetch_xf_i | input | 1 | Fetch-transform executed (strobe) |
| eoi_i | input | 1 | End-of-instruction increment (strobe) |
| mclr_i | input | 1 | Master clear (strobe) |
| cls_i | input | 2 | Decoded class of the instruction, valid with fetch_xf_i |
| step_i | input | 1 | Step mode active |
| pend_o | output | 1 | Enable pending |
| ie_set_o | output | 1 | Interrupt-enable set pulse |
| blk_o | output | 1 | Macro-halt block mask |
| clr_halt_o | output | 1 | Clear suppress-halt pulse |

## Verification
If the enable machine is in the wrong state, `pend_o` shows it at once. It also shows as a set pulse that arrives at the wrong strobe, or that never arrives, one cycle after the read or end-of-instruction strobe that should have been decisive. If the mask machine is in the wrong state, `blk_o` shows it in the cycle after the fetch-transform or end-of-instruction. Each scenario therefore compares all four outputs in every cycle, so a divergence is caught in the first cycle in which it appears.

// File: rtl/ie_defer_pkg.sv
package ie_defer_pkg;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_SIMPLE = 2'b00,
        CLS_STORE  = 2'b01,
        CLS_ENH    = 2'b10,
        CLS_SKIP2  = 2'b11
    } icls_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_ARMED, ST_WAIT_RD, ST_WAIT_EOI
    } ie_st_t;

    typedef enum logic {
        BK_OPEN, BK_HELD
    } bk_st_t;
endpackage

// File: rtl/ie_defer_fsm.sv
module ie_defer_fsm
    import ie_defer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ei,
    input  logic  rd,
    input  logic  fx,
    input  logic  eoi,
    input  logic  mclr,
    input  icls_t cls,
    output logic  pend,
    output logic  set_pulse
);
    ie_st_t st, nxt;
    logic   fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt  = st;
        fire = 1'b0;
        if (mclr) begin
            nxt = ST_IDLE;
        end else if (ei) begin
            nxt = ST_ARMED;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ARMED:
                    if (fx) nxt = (cls == CLS_SIMPLE || cls == CLS_SKIP2)
                                  ? ST_WAIT_RD : ST_WAIT_EOI;
                ST_WAIT_RD:
                    if (rd) begin
                        nxt  = ST_IDLE;
                        fire = 1'b1;
                    end
                ST_WAIT_EOI:
                    if (eoi) begin
                        nxt  = ST_IDLE;
                        fire = 1'b1;
                    end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_pulse <= 1'b0;
        else        set_pulse <= fire;
    end

    assign pend = (st != ST_IDLE);
endmodule

// File: rtl/blk_mask_fsm.sv
module blk_mask_fsm
    import ie_defer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fx,
    input  logic  eoi,
    input  logic  mclr,
    input  logic  step,
    input  icls_t cls,
    output logic  blk,
    output logic  clr_halt
);
    bk_st_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BK_OPEN;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (mclr)                           nxt = BK_OPEN;
        else if (fx && cls != CLS_SIMPLE)   nxt = BK_HELD;
        else begin
            unique case (st)
                BK_OPEN: ;
                BK_HELD: if (eoi) nxt = BK_OPEN;
                default: nxt = BK_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_halt <= 1'b0;
        else        clr_halt <= fx && step && !mclr;
    end

    assign blk = (st == BK_HELD);
endmodule

// File: rtl/ie_defer_ctl.sv
module ie_defer_ctl
    import ie_defer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ei_done_i,
    input  logic             rdnext_i,
    input  logic             fetch_xf_i,
    input  logic             eoi_i,
    input  logic             mclr_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic             step_i,
    output logic             pend_o,
    output logic             ie_set_o,
    output logic             blk_o,
    output logic             clr_halt_o
);
    icls_t cls;
    assign cls = icls_t'(cls_i);

    ie_defer_fsm u_ie (
        .clk(clk), .rst_n(rst_n), .ei(ei_done_i), .rd(rdnext_i),
        .fx(fetch_xf_i), .eoi(eoi_i), .mclr(mclr_i), .cls(cls),
        .pend(pend_o), .set_pulse(ie_set_o)
    );

    blk_mask_fsm u_bk (
        .clk(clk), .rst_n(rst_n), .fx(fetch_xf_i), .eoi(eoi_i),
        .mclr(mclr_i), .step(step_i), .cls(cls),
        .blk(blk_o), .clr_halt(clr_halt_o)
    );
endmodule

// File: rtl/ie_defer_ctl_chk.sv
module ie_defer_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ei_done_i,
    input logic       fetch_xf_i,
    input logic       eoi_i,
    input logic       mclr_i,
    input logic [1:0] cls_i,
    input logic       step_i,
    input logic       pend_o,
    input logic       ie_set_o,
    input logic       blk_o,
    input logic       clr_halt_o
);
    // R1
    mclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_i |=> (!pend_o && !ie_set_o && !blk_o && !clr_halt_o));

    // R2
    ei_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_done_i && !mclr_i) |=> (pend_o && !ie_set_o));

    // R5
    set_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set_o |-> !pend_o);

    // R5
    set_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set_o |-> $past(pend_o));

    // R5
    set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set_o |=> !ie_set_o);

    // R8
    blk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_o) |-> $past(fetch_xf_i && cls_i != 2'b00));

    // R8
    blk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_o) |-> $past(eoi_i || mclr_i));

    // R9
    clr_halt_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_xf_i && step_i && !mclr_i) |=> clr_halt_o);

    // R9
    clr_halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_halt_o |-> $past(fetch_xf_i && step_i));
endmodule

bind ie_defer_ctl ie_defer_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ei_done_i(ei_done_i), .fetch_xf_i(fetch_xf_i),
    .eoi_i(eoi_i), .mclr_i(mclr_i), .cls_i(cls_i), .step_i(step_i),
    .pend_o(pend_o), .ie_set_o(ie_set_o), .blk_o(blk_o), .clr_halt_o(clr_halt_o)
);

// File: tb/sim_ie_defer_ctl.sv
`timescale 1ns/1ps
module sim_ie_defer_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ei = 0, rd = 0, fx = 0, eoi = 0, mc = 0, step = 0;
    logic [1:0] cls = 2'b00;
    logic pend, iset, blk, clrh;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        logic  p, s, b, c;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ie_defer_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ei_done_i(ei), .rdnext_i(rd),
        .fetch_xf_i(fx), .eoi_i(eoi), .mclr_i(mc), .cls_i(cls),
        .step_i(step), .pend_o(pend), .ie_set_o(iset), .blk_o(blk),
        .clr_halt_o(clrh)
    );

    task automatic cyc(input logic i_ei, i_rd, i_fx, i_eoi, i_mc,
                       input logic [1:0] i_cls, input logic i_step,
                       input logic ep, es, eb, ec, input string tag);
        exp_t e;
        @(negedge clk);
        ei = i_ei; rd = i_rd; fx = i_fx; eoi = i_eoi; mc = i_mc;
        cls = i_cls; step = i_step;
        e.p = ep; e.s = es; e.b = eb; e.c = ec; e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if ({pend, iset, blk, clrh} !== {e.p, e.s, e.b, e.c}) begin
                n_fail++;
                $display("FAIL %s: got pend/set/blk/clrh=%b%b%b%b expected %b%b%b%b",
                         e.tag, pend, iset, blk, clrh, e.p, e.s, e.b, e.c);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if ({pend, iset, blk, clrh} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1 reset: got %b%b%b%b expected 0000", pend, iset, blk, clrh);
        end
        rst_n = 1'b1;

        // simple class: release at read, eoi ignored
        cyc(1,0,0,0,0,2'b00,0, 1,0,0,0, "R2 ei pends");
        cyc(0,1,0,0,0,2'b00,0, 1,0,0,0, "R6 read before fetch ignored");
        cyc(0,0,0,1,0,2'b00,0, 1,0,0,0, "R6 eoi before fetch ignored");
        cyc(0,0,1,0,0,2'b00,0, 1,0,0,0, "R3 simple fetch no mask");
        cyc(0,0,0,1,0,2'b00,0, 1,0,0,0, "R3 eoi does not release simple");
        cyc(0,1,0,0,0,2'b00,0, 0,1,0,0, "R3 read releases");
        cyc(0,0,0,0,0,2'b00,0, 0,0,0,0, "R5 pulse one cycle");

        // storage class: release at eoi, reads ignored
        cyc(1,0,0,0,0,2'b00,0, 1,0,0,0, "R2 ei pends again");
        cyc(0,1,0,0,0,2'b00,0, 1,0,0,0, "R6 read in armed");
        cyc(0,0,1,0,0,2'b01,0, 1,0,1,0, "R8 storage fetch masks");
        cyc(0,1,0,0,0,2'b00,0, 1,0,1,0, "R4 read does not release");
        cyc(0,0,0,1,0,2'b00,0, 0,1,0,0, "R4 eoi releases and R8 unmask");
        cyc(0,0,0,0,0,2'b00,0, 0,0,0,0, "R5 pulse ends");

        // skip type 2: masked but released at read
        cyc(1,0,0,0,0,2'b00,0, 1,0,0,0, "R2 ei");
        cyc(0,0,1,0,0,2'b11,0, 1,0,1,0, "R8 skip2 masks");
        cyc(0,0,0,1,0,2'b00,0, 1,0,0,0, "R3 skip2 eoi no release");
        cyc(0,1,0,0,0,2'b00,0, 0,1,0,0, "R3 skip2 read releases");
        cyc(0,0,0,0,0,2'b00,0, 0,0,0,0, "R5 idle");

        // enhanced with simultaneous ei and eoi
        cyc(1,0,0,0,0,2'b00,0, 1,0,0,0, "R2 ei");
        cyc(0,0,1,0,0,2'b10,0, 1,0,1,0, "R8 enhanced masks");
        cyc(1,0,0,1,0,2'b00,0, 1,0,0,0, "R7 ei wins over eoi");
        cyc(0,0,0,1,0,2'b00,0, 1,0,0,0, "R7 eoi in armed ignored");
        cyc(0,0,1,0,0,2'b00,0, 1,0,0,0, "R7 new class simple");
        cyc(0,1,0,0,0,2'b00,0, 0,1,0,0, "R7 release at read");
        cyc(0,0,0,0,0,2'b00,0, 0,0,0,0, "R5 idle");

        // step mode
        cyc(0,0,1,0,0,2'b00,1, 0,0,0,1, "R9 step clears halt");
        cyc(0,0,0,0,0,2'b00,1, 0,0,0,0, "R9 pulse one cycle");
        cyc(0,0,1,0,0,2'b10,1, 0,0,1,1, "R9 step with mask");
        cyc(0,0,0,0,0,2'b00,0, 0,0,1,0, "R8 mask held");
        cyc(0,0,0,1,0,2'b00,0, 0,0,0,0, "R8 eoi releases mask");
        cyc(0,0,1,0,0,2'b00,0, 0,0,0,0, "R9 no step no pulse");

        // master clear
        cyc(1,0,0,0,0,2'b00,0, 1,0,0,0, "R2 ei");
        cyc(0,0,1,0,0,2'b01,1, 1,0,1,1, "R8 mask before clear");
        cyc(0,0,0,0,1,2'b00,0, 0,0,0,0, "R1 master clear");
        cyc(1,0,1,0,1,2'b01,1, 0,0,0,0, "R1 clear beats ei fetch step");
        cyc(0,0,0,0,0,2'b00,0, 0,0,0,0, "R1 stays clear");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule